// File: doc/BRIEF.md
# Vector Element Iteration Sequencer

This block sits next to a small multi-cycle 32-bit integer core and turns one vector instruction into a run of back-to-back scalar element operations. The low two bits of every instruction word tell scalar from vector. For a vector instruction the core keeps the same instruction in its execute stage, and the sequencer walks an element index from 0 up to the current vector length minus one. For each element it maps the vector register operands onto scalar register-file indices, so the vector registers are slices of the scalar register file and need no storage of their own.

The core pulses `step_i` each time the current element's operation has finished, whether that takes one cycle or many. The sequencer raises `done_o` on the step that finishes the last element, and the core then fetches the next instruction. A set-length instruction loads the vector length register, clamped to the build-time maximum, and supplies the clamped value for write-back to its destination register. Loads, stores and register-immediate ALU operations whose second operand is marked as a vector get a generated stride in place of the immediate: zero for the first element, then IMM, 2*IMM and so on. Software should not name vector register 0, because it overlays the scalar zero register.

Top module: `velem_sequencer`

## Requirements
- R1: `is_vec_o` is high exactly when `insn_i[1:0]` is not 2'b11, and `insn_norm_o` equals `insn_i` with bits [1:0] forced to 2'b11.
- R2: When `insn_i[1]` is 0, the destination (field [11:7]) and source 2 (field [24:20]) are vectors. When `insn_i[0]` is 0, source 1 (field [19:15]) is a vector. A vector operand with register number k at element i drives index {k[2:0], i[1:0]}. A scalar operand passes its 5-bit field through unchanged.
- R3: After reset the vector length `vl_o` equals VLMAX (4).
- R4: A set-length instruction is a scalar word with opcode bits [6:0] = 1010111 and funct3 bits [14:12] = 111. `vl_wb_o` always shows min(`rs1_data_i`, VLMAX). On a step of a set-length instruction, the vector length register takes that value. `vl_o` changes at no other time.
- R5: For a scalar instruction, `done_o` equals `step_i`. For a vector instruction, `done_o` is high only on the step where the element index equals VL-1.
- R6: The element index `elem_idx_o` advances by one only on a step that is not the last. In cycles without a step it holds, however long a multi-cycle element takes.
- R7: The element index is 0 after reset and after every completing step, so every instruction starts at element 0.
- R8: The immediate is the sign-extended S-type value (bits [31:25], [11:7]) when the opcode is 0100011, and the sign-extended I-type value (bits [31:20]) for every other opcode. For opcodes 0000011, 0100011 and 0010011 with `insn_i[1]` = 0, `imm_o` is element index times that immediate, modulo 2^32.
- R9: When VL is 0, a vector instruction drives `elem_active_o` low and completes on its first step. In every other case `elem_active_o` is high.
- R10: Scalar instructions, and vector instructions with another opcode or with `insn_i[1]` = 1, get the plain decoded immediate on `imm_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_i | input | 32 | Instruction word held in execute |
| step_i | input | 1 | Current element operation completes this cycle |
| rs1_data_i | input | 32 | Source 1 value, used by set-length |
| is_vec_o | output | 1 | Instruction is vector-marked |
| insn_norm_o | output | 32 | Instruction with low bits restored to 11 |
| rd_idx_o | output | 5 | Destination register-file index |
| rs1_idx_o | output | 5 | Source 1 register-file index |
| rs2_idx_o | output | 5 | Source 2 register-file index |
| imm_o | output | 32 | Immediate or generated stride |
| elem_idx_o | output | 2 | Current element index |
| elem_active_o | output | 1 | Element operation should take effect |
| done_o | output | 1 | Instruction finishes with this step |
| vl_o | output | 3 | Vector length register |
| vl_wb_o | output | 32 | Clamped length for write-back |

## Verification
Decode, index mapping, the immediate, `vl_wb_o`, `elem_active_o` and `done_o` are combinational in the instruction word, the step and the stored state, so they are due in the same cycle as the stimulus. The element index, the stride accumulator and the vector length change on the rising edge that takes a step, and they are visible from the next cycle. The bench drives inputs just after the falling edge and samples one time unit later. In that sample it compares the combinational results against a model whose state it updates only for steps that cross a rising edge. Random stall cycles with no step are placed between element steps to show that the index holds until the multi-cycle operation completes.

// File: rtl/velem_pkg.sv
package velem_pkg;
   localparam int FIELD_W = 5;
   localparam int XLEN    = 32;

   localparam logic [6:0] OPC_LOAD  = 7'b0000011;
   localparam logic [6:0] OPC_STORE = 7'b0100011;
   localparam logic [6:0] OPC_OPIMM = 7'b0010011;
   localparam logic [6:0] OPC_VSET  = 7'b1010111;

   typedef struct packed {
      logic                is_vec;
      logic                vec_d2;
      logic                vec_s1;
      logic                is_setvl;
      logic                uses_imm;
      logic [FIELD_W-1:0]  rd;
      logic [FIELD_W-1:0]  rs1;
      logic [FIELD_W-1:0]  rs2;
      logic [XLEN-1:0]     imm;
      logic [XLEN-1:0]     norm;
   } vdec_t;
endpackage

// File: rtl/velem_decode.sv
module velem_decode
   import velem_pkg::*;
(
   input  logic [XLEN-1:0] insn,
   output vdec_t           dec
);
   logic [XLEN-1:0] norm;
   logic [6:0]      opc;

   assign norm = {insn[XLEN-1:2], 2'b11};
   assign opc  = norm[6:0];

   always_comb begin
      dec          = '0;
      dec.norm     = norm;
      dec.is_vec   = (insn[1:0] != 2'b11);
      dec.vec_d2   = ~insn[1];
      dec.vec_s1   = ~insn[0];
      dec.is_setvl = (insn[1:0] == 2'b11) && (opc == OPC_VSET) && (norm[14:12] == 3'b111);
      dec.uses_imm = (opc == OPC_LOAD) || (opc == OPC_STORE) || (opc == OPC_OPIMM);
      dec.rd       = norm[11:7];
      dec.rs1      = norm[19:15];
      dec.rs2      = norm[24:20];
      if (opc == OPC_STORE)
         dec.imm = {{20{norm[31]}}, norm[31:25], norm[11:7]};
      else
         dec.imm = {{20{norm[31]}}, norm[31:20]};
   end
endmodule

// File: rtl/velem_vl.sv
module velem_vl #(
   parameter int VLMAX = 4,
   parameter int XLEN  = 32,
   localparam int VL_W = $clog2(VLMAX + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [XLEN-1:0] rs1_data,
   output logic [VL_W-1:0] vl,
   output logic [XLEN-1:0] wb
);
   logic [VL_W-1:0] clamped;

   assign clamped = (rs1_data < XLEN'(VLMAX)) ? rs1_data[VL_W-1:0] : VL_W'(VLMAX);
   assign wb      = XLEN'(clamped);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vl <= VL_W'(VLMAX);
      else if (wr_en) vl <= clamped;
   end

   p_vl_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vl <= VL_W'(VLMAX));
   p_vl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(vl));
endmodule

// File: rtl/velem_iter.sv
module velem_iter #(
   parameter int VLMAX     = 4,
   parameter int XLEN      = 32,
   parameter bit STRIDE_EN = 1'b1,
   localparam int EW       = $clog2(VLMAX)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic            last,
   input  logic [XLEN-1:0] imm,
   output logic [EW-1:0]   cnt,
   output logic [XLEN-1:0] acc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (step) cnt <= last ? '0 : cnt + EW'(1);
   end

   generate
      if (STRIDE_EN) begin : g_stride
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    acc <= '0;
            else if (step) acc <= last ? '0 : acc + imm;
         end
         p_acc_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == '0) |-> (acc == '0));
      end else begin : g_nostride
         assign acc = '0;
      end
   endgenerate

   p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last) |=> (cnt == '0));
   p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt));
endmodule

// File: rtl/velem_sequencer.sv
module velem_sequencer
   import velem_pkg::*;
#(
   parameter int VLMAX     = 4,
   parameter bit STRIDE_EN = 1'b1,
   localparam int EW       = $clog2(VLMAX),
   localparam int VL_W     = $clog2(VLMAX + 1),
   localparam int VR_W     = FIELD_W - EW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [XLEN-1:0]    insn_i,
   input  logic               step_i,
   input  logic [XLEN-1:0]    rs1_data_i,
   output logic               is_vec_o,
   output logic [XLEN-1:0]    insn_norm_o,
   output logic [FIELD_W-1:0] rd_idx_o,
   output logic [FIELD_W-1:0] rs1_idx_o,
   output logic [FIELD_W-1:0] rs2_idx_o,
   output logic [XLEN-1:0]    imm_o,
   output logic [EW-1:0]      elem_idx_o,
   output logic               elem_active_o,
   output logic               done_o,
   output logic [VL_W-1:0]    vl_o,
   output logic [XLEN-1:0]    vl_wb_o
);
   generate
      if (VLMAX < 2 || (VLMAX & (VLMAX - 1)) != 0) begin : g_bad_vlmax
         $error("VLMAX must be a power of two of at least 2");
      end
      if (EW >= FIELD_W) begin : g_bad_width
         $error("VLMAX leaves no bits for the vector register number");
      end
   endgenerate

   vdec_t           dec;
   logic [VL_W-1:0] vl;
   logic [EW-1:0]   cnt;
   logic [XLEN-1:0] acc;
   logic            last;

   velem_decode u_dec (.insn(insn_i), .dec(dec));

   velem_vl #(.VLMAX(VLMAX), .XLEN(XLEN)) u_vl (
      .clk(clk), .rst_n(rst_n), .wr_en(step_i && dec.is_setvl),
      .rs1_data(rs1_data_i), .vl(vl), .wb(vl_wb_o));

   assign last = !dec.is_vec || (VL_W'(cnt) + VL_W'(1) >= vl);

   velem_iter #(.VLMAX(VLMAX), .XLEN(XLEN), .STRIDE_EN(STRIDE_EN)) u_iter (
      .clk(clk), .rst_n(rst_n), .step(step_i), .last(last),
      .imm(dec.imm), .cnt(cnt), .acc(acc));

   function automatic logic [FIELD_W-1:0] map_idx(input logic [FIELD_W-1:0] f,
                                                  input logic vec,
                                                  input logic [EW-1:0] i);
      return vec ? {f[VR_W-1:0], i} : f;
   endfunction

   assign is_vec_o      = dec.is_vec;
   assign insn_norm_o   = dec.norm;
   assign rd_idx_o      = map_idx(dec.rd,  dec.vec_d2, cnt);
   assign rs1_idx_o     = map_idx(dec.rs1, dec.vec_s1, cnt);
   assign rs2_idx_o     = map_idx(dec.rs2, dec.vec_d2, cnt);
   assign imm_o         = (dec.vec_d2 && dec.uses_imm) ? acc : dec.imm;
   assign elem_idx_o    = cnt;
   assign elem_active_o = !dec.is_vec || (vl != '0);
   assign done_o        = step_i && last;
   assign vl_o          = vl;

   p_scalar_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !is_vec_o) |-> done_o);
   p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (elem_idx_o == '0) || (VL_W'(elem_idx_o) < vl_o));
   p_zero_vl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_vec_o && !elem_active_o && step_i) |-> done_o);
endmodule

// File: tb/velem_sequencer_bench.sv
module velem_sequencer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int VLMAX = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] insn_i = 32'h0000_0013;
   logic        step_i = 1'b0;
   logic [31:0] rs1_data_i = '0;
   logic        is_vec_o, elem_active_o, done_o;
   logic [31:0] insn_norm_o, imm_o, vl_wb_o;
   logic [4:0]  rd_idx_o, rs1_idx_o, rs2_idx_o;
   logic [1:0]  elem_idx_o;
   logic [2:0]  vl_o;

   int n_checks = 0;
   int n_fail = 0;
   int m_vl = VLMAX;
   int m_i = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   velem_sequencer u_velem_sequencer (
      .clk(clk), .rst_n(rst_n), .insn_i(insn_i), .step_i(step_i),
      .rs1_data_i(rs1_data_i), .is_vec_o(is_vec_o), .insn_norm_o(insn_norm_o),
      .rd_idx_o(rd_idx_o), .rs1_idx_o(rs1_idx_o), .rs2_idx_o(rs2_idx_o),
      .imm_o(imm_o), .elem_idx_o(elem_idx_o), .elem_active_o(elem_active_o),
      .done_o(done_o), .vl_o(vl_o), .vl_wb_o(vl_wb_o));

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] exp_idx(input logic [4:0] f, input bit vec, input int i);
      return vec ? {f[2:0], 2'(i)} : f;
   endfunction

   function automatic logic [31:0] exp_imm(input logic [31:0] ins, input int i);
      logic [6:0]  opc;
      logic [31:0] base;
      opc = {ins[6:2], 2'b11};
      if (opc == 7'b0100011) base = {{20{ins[31]}}, ins[31:25], ins[11:7]};
      else                   base = {{20{ins[31]}}, ins[31:20]};
      if ((opc == 7'b0000011 || opc == 7'b0100011 || opc == 7'b0010011) && !ins[1])
         return base * 32'(i);
      return base;
   endfunction

   function automatic bit is_setvl(input logic [31:0] ins);
      return ins[6:0] == 7'b1010111 && ins[14:12] == 3'b111;
   endfunction

   function automatic int clamp(input logic [31:0] r);
      return (r < 32'(VLMAX)) ? int'(r) : VLMAX;
   endfunction

   task automatic check_all(input logic [31:0] ins, input logic [31:0] r1, input bit st);
      bit vec;
      bit exp_done;
      vec = (ins[1:0] != 2'b11);
      exp_done = st && (!vec || m_vl == 0 || m_i == m_vl - 1);
      chk(is_vec_o == vec, "R1 is_vec", 32'(is_vec_o), 32'(vec));
      chk(insn_norm_o == {ins[31:2], 2'b11}, "R1 norm", insn_norm_o, {ins[31:2], 2'b11});
      chk(rd_idx_o == exp_idx(ins[11:7], !ins[1], m_i), "R2 rd", 32'(rd_idx_o),
          32'(exp_idx(ins[11:7], !ins[1], m_i)));
      chk(rs1_idx_o == exp_idx(ins[19:15], !ins[0], m_i), "R2 rs1", 32'(rs1_idx_o),
          32'(exp_idx(ins[19:15], !ins[0], m_i)));
      chk(rs2_idx_o == exp_idx(ins[24:20], !ins[1], m_i), "R2 rs2", 32'(rs2_idx_o),
          32'(exp_idx(ins[24:20], !ins[1], m_i)));
      chk(imm_o == exp_imm(ins, m_i), "R8 R10 imm", imm_o, exp_imm(ins, m_i));
      chk(int'(elem_idx_o) == m_i, "R6 R7 elem_idx", 32'(elem_idx_o), 32'(m_i));
      chk(done_o == exp_done, "R5 done", 32'(done_o), 32'(exp_done));
      chk(elem_active_o == (!vec || m_vl != 0), "R9 active", 32'(elem_active_o),
          32'(!vec || m_vl != 0));
      chk(int'(vl_o) == m_vl, "R3 R4 vl", 32'(vl_o), 32'(m_vl));
      chk(int'(vl_wb_o) == clamp(r1), "R4 vl_wb", vl_wb_o, 32'(clamp(r1)));
   endtask

   task automatic run_insn(input logic [31:0] ins, input logic [31:0] r1, input int max_wait);
      int n;
      bit vec;
      vec = (ins[1:0] != 2'b11);
      n = vec ? ((m_vl == 0) ? 1 : m_vl) : 1;
      for (int e = 0; e < n; e++) begin
         int w;
         w = (max_wait > 0) ? int'($urandom_range(0, max_wait)) : 0;
         for (int k = 0; k < w; k++) begin
            @(negedge clk);
            insn_i = ins; rs1_data_i = r1; step_i = 1'b0;
            #1 check_all(ins, r1, 1'b0);
         end
         @(negedge clk);
         insn_i = ins; rs1_data_i = r1; step_i = 1'b1;
         #1 check_all(ins, r1, 1'b1);
         if (!vec || m_vl == 0 || m_i == m_vl - 1) begin
            m_i = 0;
            if (!vec && is_setvl(ins)) m_vl = clamp(r1);
         end else begin
            m_i++;
         end
      end
   endtask

   function automatic logic [31:0] setvl_word(input logic [4:0] rd);
      return {12'h800, 5'd12, 3'b111, rd, 7'b1010111};
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      repeat (3) @(negedge clk);
      #1;
      chk(vl_o == 3'd4, "R3 reset vl", 32'(vl_o), 32'd4);
      chk(elem_idx_o == 2'd0, "R7 reset idx", 32'(elem_idx_o), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R9 zero length: vector op completes on first step, inactive
      run_insn(setvl_word(5'd14), 32'd0, 0);
      run_insn(32'h0085_2381, 32'd0, 1);
      // R4 clamp to VLMAX and partial length
      run_insn(setvl_word(5'd14), 32'd100, 0);
      run_insn(32'h0085_2381, 32'd0, 2);
      run_insn(setvl_word(5'd15), 32'd3, 1);
      // R8 store with negative stride, vector source 1 too
      run_insn(32'hFE75_2E20, 32'd0, 2);
      // R10 register-register vector op keeps plain immediate
      run_insn(32'h00B5_0530, 32'd0, 1);

      for (int t = 0; t < 200; t++) begin
         logic [31:0] ins;
         logic [31:0] r1;
         int sel;
         sel = int'($urandom_range(0, 4));
         ins = $urandom;
         r1  = ($urandom_range(0, 1) == 1) ? 32'($urandom_range(0, 6)) : $urandom;
         case (sel)
            0: ins[6:2] = 5'b00000;
            1: ins[6:2] = 5'b01000;
            2: ins[6:2] = 5'b00100;
            3: ins[6:2] = 5'b01100;
            default: begin
               ins[6:0] = 7'b1010111;
               ins[14:12] = 3'b111;
            end
         endcase
         run_insn(ins, r1, 2);
      end

      @(negedge clk);
      step_i = 1'b0;
      #1;
      chk(elem_idx_o == 2'd0, "R7 idle idx", 32'(elem_idx_o), 32'd0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule